// File: doc/BRIEF.md
# Converter Serial Data Output Port

This block is the device side of a three-wire serial link on a 12-bit sampling converter. A host lowers the active-low select line to begin a frame. It then toggles the serial clock, and the block shifts a conversion result out on a single data line. The serial clock also paces the conversion, so the block counts falling clock edges. From that count it reports when the sampling window closes and when conversion finishes.

The result register is captured at the moment the frame opens. The output starts driving a zero on that same event, before any clock edge arrives. Each later falling clock edge then launches the next bit in this order: a second zero, the twelve result bits from the most significant down, and then zeros. The line is released after the sixteenth falling edge, or at once if the select line goes high. The select and clock inputs are sampled by the block's own fabric clock. The output is split into a data bit and a drive enable that feed a tri-state pad.

Top module: `sar_sdo_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sdo_oe`, `sample_done` and `conv_done` are 0, and any frame in progress is dropped.
- R2: A high-to-low change of `cs_n` sets `sdo_oe` to 1 with `sdo_d` at 0 (the first leading zero) in the next `clk` cycle, without waiting for any `sck` edge.
- R3: Counting falling `sck` edges from 1 within a frame, edge 1 launches the second leading zero and edge k (k = 2..13) launches result bit 13-k, so bit 11 (MSB) comes on edge 2 and bit 0 on edge 13. Each bit appears on `sdo_d` one `clk` cycle after the falling edge is sampled, and it changes only then.
- R4: Edges 14 and 15 launch zeros, so the final bit of a 16-edge frame is launched on edge 15 and is still held at edge 16.
- R5: Falling edge 16 sets `sdo_oe` to 0. Further `sck` edges while `cs_n` stays low leave it at 0 until a new frame is opened.
- R6: `cs_n` high at any point in a frame clears `sdo_oe` in the next cycle and resets the edge count. The next frame starts again from the first leading zero.
- R7: `result` is captured when the frame opens. Changes to `result` during a frame do not alter the bits sent.
- R8: `sample_done` is a one-cycle pulse after falling edge 1 of a frame, marking the end of acquisition. It pulses at no other time.
- R9: `conv_done` is a one-cycle pulse after falling edge 14 (1 + 13 conversion clocks). It does not pulse in a frame that `cs_n` ends earlier.
- R10: `sck` activity while `cs_n` is high leaves `sdo_oe`, `sample_done` and `conv_done` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock that samples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sck | input | 1 | Serial and conversion clock from the host |
| result | input | 12 | Conversion result to transmit |
| sdo_d | output | 1 | Serial data value for the pad |
| sdo_oe | output | 1 | Pad drive enable; 0 means high impedance |
| sample_done | output | 1 | One-cycle pulse when acquisition ends |
| conv_done | output | 1 | One-cycle pulse when conversion completes |

## Verification
The bench checks each bit position of several result patterns, including all-ones and alternating values. A design that launched the first zero on a clock edge instead of on select would shift every later bit one edge late and fail on the MSB. The bench aborts a frame midway and then opens a fresh one. A design that kept its edge count would resume mid-word, and one that let the abort reach edge 14 would pulse `conv_done`. It changes `result` mid-frame, which catches a design that reads the live input instead of the captured copy. It clocks past edge 16 with select still low, which exposes a line that is driven again after the frame has ended.

// File: rtl/sar_sdo_pkg.sv
package sar_sdo_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_DONE  = 2'd2
  } frame_state_t;

endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic [W-1:0] fall
);

  logic [W-1:0] sig_q;

  // previous-sample register, reset low so no falling edge is seen at release
  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_fall
    assign fall[i] = sig_q[i] & ~sig[i];
  end

endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_sdo_pkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int SAMPLE_EDGE = 1,
  parameter int CONV_CLKS   = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic cs_fall,
  input  logic sck_fall,
  output logic load,
  output logic shift,
  output logic last,
  output logic sample_done,
  output logic conv_done
);

  localparam int CNT_W = $clog2(FRAME_EDGES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT   = CNT_W'(FRAME_EDGES);
  localparam logic [CNT_W-1:0] SAMPLE_CNT = CNT_W'(SAMPLE_EDGE);
  localparam logic [CNT_W-1:0] CONV_CNT   = CNT_W'(SAMPLE_EDGE + CONV_CLKS);

  frame_state_t      state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;

  assign cnt_nxt = cnt + 1'b1;
  assign load    = cs_fall & ~cs_n & (state == FR_IDLE);
  assign shift   = sck_fall & ~cs_n & (state == FR_SHIFT);
  assign last    = shift & (cnt_nxt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      state <= FR_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        FR_IDLE: begin
          if (load) begin
            state <= FR_SHIFT;
            cnt   <= '0;
          end
        end
        FR_SHIFT: begin
          if (shift) begin
            cnt <= cnt_nxt;
            if (last) state <= FR_DONE;
          end
        end
        default: state <= state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_done <= 1'b0;
      conv_done   <= 1'b0;
    end else begin
      sample_done <= shift & (cnt_nxt == SAMPLE_CNT);
      conv_done   <= shift & (cnt_nxt == CONV_CNT);
    end
  end

endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              load,
  input  logic              shift,
  input  logic              last,
  input  logic [DATA_W-1:0] result,
  output logic              sdo_d,
  output logic              sdo_oe
);

  // bits that follow the first leading zero, which is driven on load
  localparam int SH_W = DATA_W + LEAD_ZEROS - 1;

  logic [SH_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      sdo_d <= 1'b0;
    end else if (load) begin
      shreg <= SH_W'(result);
      sdo_d <= 1'b0;
    end else if (shift) begin
      shreg <= {shreg[SH_W-2:0], 1'b0};
      sdo_d <= shreg[SH_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || cs_n)   sdo_oe <= 1'b0;
    else if (load)     sdo_oe <= 1'b1;
    else if (last)     sdo_oe <= 1'b0;
  end

endmodule

// File: rtl/sar_sdo_port.sv
module sar_sdo_port #(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 2,
  parameter int FRAME_EDGES = 16,
  parameter int SAMPLE_EDGE = 1,
  parameter int CONV_CLKS   = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [DATA_W-1:0] result,
  output logic              sdo_d,
  output logic              sdo_oe,
  output logic              sample_done,
  output logic              conv_done
);

  logic [1:0] falls;
  logic       load;
  logic       shift;
  logic       last;

  sar_edge_det #(.W(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig  ({sck, cs_n}),
    .fall (falls)
  );

  sar_frame_ctl #(
    .FRAME_EDGES (FRAME_EDGES),
    .SAMPLE_EDGE (SAMPLE_EDGE),
    .CONV_CLKS   (CONV_CLKS)
  ) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .cs_fall     (falls[0]),
    .sck_fall    (falls[1]),
    .load        (load),
    .shift       (shift),
    .last        (last),
    .sample_done (sample_done),
    .conv_done   (conv_done)
  );

  sar_shift_out #(
    .DATA_W     (DATA_W),
    .LEAD_ZEROS (LEAD_ZEROS)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .load   (load),
    .shift  (shift),
    .last   (last),
    .result (result),
    .sdo_d  (sdo_d),
    .sdo_oe (sdo_oe)
  );

endmodule

// File: rtl/sar_sdo_port_chk.sv
module sar_sdo_port_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sck,
  input logic sdo_d,
  input logic sdo_oe,
  input logic sample_done,
  input logic conv_done
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!sdo_oe && !sample_done && !conv_done)); // R1

  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(cs_n) && !sdo_oe) |=> (sdo_oe && !sdo_d)); // R2

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && $past(sdo_oe) && (sdo_d != $past(sdo_d)))
      |-> ($past(sck, 2) && !$past(sck))); // R3

  AST_SELECT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!sdo_oe && !sample_done && !conv_done)); // R6

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sample_done |=> !sample_done); // R8

  AST_CONV_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !conv_done); // R9

  AST_PULSES_APART: assert property (@(posedge clk) disable iff (rst)
    !(sample_done && conv_done)); // R9

endmodule

bind sar_sdo_port sar_sdo_port_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n        (cs_n),
  .sck         (sck),
  .sdo_d       (sdo_d),
  .sdo_oe      (sdo_oe),
  .sample_done (sample_done),
  .conv_done   (conv_done)
);

// File: tb/tb_sar_sdo_port.sv
module tb_sar_sdo_port;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;
  localparam logic [11:0] VEC [NVEC] = '{12'hFFF, 12'h000, 12'hA5A, 12'h555, 12'h801, 12'h3C7};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic [11:0] result = '0;
  logic        sdo_d, sdo_oe, sample_done, conv_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_sdo_port dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .result(result),
    .sdo_d(sdo_d), .sdo_oe(sdo_oe), .sample_done(sample_done), .conv_done(conv_done)
  );

  // expected bit launched at falling edge k (k = 0 is the select edge)
  function automatic logic exp_bit(input logic [11:0] r, input int k);
    if (k >= 2 && k <= 13) return r[13-k];
    return 1'b0;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sck_fall();
    sck = 1'b1; cyc();
    sck = 1'b0; cyc();
  endtask

  task automatic open_frame();
    cs_n = 1'b0; cyc();
  endtask

  task automatic close_frame();
    cs_n = 1'b1; cyc(); cyc();
  endtask

  // full 16-edge frame with every bit and pulse checked
  task automatic run_frame(input logic [11:0] r);
    result = r;
    open_frame();
    check("R2 oe", sdo_oe, 1);
    check("R2 first zero", sdo_d, 0);
    for (int k = 1; k <= 16; k++) begin
      sck_fall();
      check("R8 sample_done", sample_done, (k == 1));
      check("R9 conv_done", conv_done, (k == 14));
      if (k < 16) begin
        check("R3 oe during frame", sdo_oe, 1);
        if (k >= 14) check("R4 trailing zero", sdo_d, exp_bit(r, k));
        else         check("R3 bit", sdo_d, exp_bit(r, k));
      end else begin
        check("R5 released at edge 16", sdo_oe, 0);
      end
    end
    sck_fall();
    check("R5 stays released", sdo_oe, 0);
    check("R8 no extra sample pulse", sample_done, 0);
    close_frame();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] a;
    logic [11:0] b;
    cyc(); cyc();
    check("R1 oe in reset", sdo_oe, 0);
    rst = 1'b0; cyc();
    check("R1 oe after reset", sdo_oe, 0);
    check("R1 sample_done after reset", sample_done, 0);
    check("R1 conv_done after reset", conv_done, 0);

    // R10: clocks with select high
    for (int k = 0; k < 20; k++) begin
      sck_fall();
      check("R10 oe idle", sdo_oe, 0);
      check("R10 no pulse", sample_done | conv_done, 0);
    end

    for (int v = 0; v < NVEC; v++) run_frame(VEC[v]);

    // R7: result change mid-frame is ignored
    a = 12'hC3A; b = 12'h35C;
    result = a;
    open_frame();
    for (int k = 1; k <= 15; k++) begin
      if (k == 4) result = b;
      sck_fall();
      check("R7 captured bit", sdo_d, exp_bit(a, k));
    end
    close_frame();

    // R6: abort after edge 6, then new frame restarts from first zero
    result = 12'hFFF;
    open_frame();
    for (int k = 1; k <= 6; k++) sck_fall();
    cs_n = 1'b1; cyc();
    check("R6 abort releases", sdo_oe, 0);
    for (int k = 0; k < 10; k++) begin
      sck_fall();
      check("R9 no conv after abort", conv_done, 0);
    end
    open_frame();
    check("R6 restart first zero", sdo_d, 0);
    check("R6 restart oe", sdo_oe, 1);
    sck_fall();
    check("R6 restart second zero", sdo_d, 0);
    check("R6 restart sample pulse", sample_done, 1);
    sck_fall();
    check("R6 restart MSB", sdo_d, 1);

    // R1: reset in mid-frame
    rst = 1'b1; cyc();
    check("R1 reset drops frame", sdo_oe, 0);
    rst = 1'b0; cyc();
    sck_fall();
    check("R1 no frame after reset", sdo_oe, 0);
    check("R1 no pulse after reset", sample_done, 0);
    close_frame();

    // select lowered while sck high: first zero still driven at once
    result = 12'h800;
    sck = 1'b1; cyc();
    cs_n = 1'b0; cyc();
    check("R2 zero with sck high", sdo_oe & ~sdo_d, 1);
    sck = 1'b0; cyc();
    check("R3 second zero", sdo_d, 0);
    sck_fall();
    check("R3 MSB after sck high start", sdo_d, 1);
    close_frame();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule